// File: doc/BRIEF.md
# Timed Output Sample Lane Placer

This block sits between an output sample FIFO and a 32-line timed output bus. On every update strobe it takes one sample, either from the head of the FIFO or, when the FIFO path is bypassed, from a local direct-data register. It then writes that sample onto a programmable part of the bus. The sample may be 8, 16 or 32 bits wide. A lane select picks which byte or halfword of the bus receives a narrow sample. Bus lines outside the written lanes keep the value they already had.

The FIFO storage lives outside the block. The FIFO is first-word-fall-through: its head word is always presented on `fifo_rd_data`, and the block returns a one-cycle pop request. The block also registers the FIFO occupancy into a 16-bit status word.

A change of sample width puts the FIFO path on hold until the FIFO has been cleared. A strobe that finds the FIFO empty leaves the bus untouched and raises a sticky underflow flag.

Top module: `tos_lane_placer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_lines`, `underflow` and `fill_status` read 0, and `fifo_pop` is low.
- R2: With `cfg_width`=0 (8-bit samples), a strobe writes sample bits 7:0 to bus bits 7:0, 15:8, 23:16 or 31:24 for `cfg_lane` 0, 1, 2 or 3, and all other bus bits hold.
- R3: With `cfg_width`=1 (16-bit samples), a strobe writes sample bits 15:0 to bus bits 15:0 when `cfg_lane` bit 0 is 0, and to bits 31:16 when that bit is 1 (lane values 2 and 3 act as 0 and 1). The other halfword holds.
- R4: With `cfg_width`=2 (32-bit), or with the spare code 3, a strobe writes the whole sample to the whole bus, whatever the value of `cfg_lane`.
- R5: A strobe with `cfg_bypass`=0, the FIFO path not on hold and a non-empty FIFO raises `fifo_pop` for exactly that cycle. The popped head word appears on `out_lines` after the next rising edge.
- R6: Without a strobe, `fifo_pop` stays low and `out_lines` holds.
- R7: A FIFO-path strobe that meets `fifo_count`=0 does not pop and leaves `out_lines` unchanged. It sets `underflow`, which stays high until reset.
- R8: With `cfg_bypass`=1, a strobe places the value held in the direct-data register (loaded by `dir_wr`) and never pops or flags underflow. A `dir_wr` in the same cycle as the strobe affects only later strobes.
- R9: `fill_status` equals `fifo_count`, zero-extended to 16 bits, one cycle after it is presented.
- R10: After any change of `cfg_width`, FIFO-path strobes are ignored: no pop, no bus change, no underflow. This lasts until a `fifo_clr` pulse arrives in a cycle with no further width change. Bypass strobes keep working throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 2 | Sample width: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| cfg_lane | input | 2 | Byte lane (8-bit) or halfword lane in bit 0 (16-bit) |
| cfg_bypass | input | 1 | 1 = take samples from the direct-data register |
| fifo_clr | input | 1 | Pulse seen when the external FIFO is cleared; releases the width hold |
| upd_strobe | input | 1 | Update strobe, one sample per high cycle |
| fifo_rd_data | input | 32 | Head word of the FIFO (first-word fall-through) |
| fifo_count | input | 11 | Words currently held in the FIFO |
| fifo_pop | output | 1 | Pop request for the FIFO head |
| dir_wr | input | 1 | Load strobe for the direct-data register |
| dir_data | input | 32 | Value for the direct-data register |
| out_lines | output | 32 | Timed output bus |
| underflow | output | 1 | Sticky flag: a FIFO strobe found the FIFO empty |
| fill_status | output | 16 | Registered FIFO occupancy |

## Verification
Byte samples are stepped through all four lanes with distinct values. Each lane must therefore leave a different fingerprint, and a lane decode error shows as a wrong byte or a disturbed neighbour. Halfword samples use all four lane codes, which separates use of lane bit 0 from use of the full field. Word samples are run with nonzero lane values and with the spare width code. Strobes against an empty FIFO, in bypass, and in the window after a width change tell apart the three ways a strobe can fail to pop. Idle cycles between strobes show that the bus holds.

// File: rtl/tos_pkg.sv
package tos_pkg;
  typedef enum logic [1:0] {
    SW_BYTE = 2'd0,
    SW_HALF = 2'd1,
    SW_WORD = 2'd2,
    SW_SPARE = 2'd3
  } smp_width_e;
endpackage

// File: rtl/tos_lane_mask.sv
module tos_lane_mask
  import tos_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic [1:0]        width,
  input  logic [1:0]        lane,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] wdata,
  output logic [NBYTE-1:0]  bena
);
  // one slice per output byte: pick its enable and its source byte
  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    always_comb begin
      unique case (smp_width_e'(width))
        SW_BYTE: begin
          bena[b] = (lane == 2'(b));
          wdata[b*8 +: 8] = sample[7:0];
        end
        SW_HALF: begin
          bena[b] = ((b / 2) == int'(lane[0]));
          wdata[b*8 +: 8] = sample[(b % 2)*8 +: 8];
        end
        default: begin
          bena[b] = 1'b1;
          wdata[b*8 +: 8] = sample[b*8 +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/tos_src_sel.sv
module tos_src_sel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_bypass,
  input  logic              fifo_clr,
  input  logic              upd_strobe,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  input  logic              dir_wr,
  input  logic [DATA_W-1:0] dir_data,
  output logic              fifo_pop,
  output logic              load,
  output logic [DATA_W-1:0] sample,
  output logic              underflow
);
  logic [DATA_W-1:0] dreg;
  logic [1:0]        width_q;
  logic              stale;
  logic              fifo_req;

  assign fifo_req = upd_strobe && !cfg_bypass && !stale && !rst;
  assign fifo_pop = fifo_req && !fifo_empty;
  assign load     = (upd_strobe && cfg_bypass && !rst) || fifo_pop;
  assign sample   = cfg_bypass ? dreg : fifo_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      dreg      <= '0;
      width_q   <= cfg_width;
      stale     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      width_q <= cfg_width;
      if (dir_wr) dreg <= dir_data;
      if (cfg_width != width_q) stale <= 1'b1;
      else if (fifo_clr)        stale <= 1'b0;
      if (fifo_req && fifo_empty) underflow <= 1'b1;
    end
  end

  p_pop_has_data_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);
  p_sticky_uf_r7: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  p_empty_sets_uf_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && !cfg_bypass && !stale && fifo_empty) |=> underflow);
  p_bypass_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_bypass |-> !fifo_pop);
  p_hold_no_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_width != width_q) |=> !fifo_pop);
endmodule

// File: rtl/tos_lane_placer.sv
module tos_lane_placer
  import tos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11,
  parameter int STAT_W = 16,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_lane,
  input  logic              cfg_bypass,
  input  logic              fifo_clr,
  input  logic              upd_strobe,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_pop,
  input  logic              dir_wr,
  input  logic [DATA_W-1:0] dir_data,
  output logic [DATA_W-1:0] out_lines,
  output logic              underflow,
  output logic [STAT_W-1:0] fill_status
);
  logic              load;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] wdata;
  logic [NBYTE-1:0]  bena;

  tos_src_sel #(.DATA_W(DATA_W)) u_src (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_bypass(cfg_bypass),
    .fifo_clr(fifo_clr), .upd_strobe(upd_strobe), .fifo_rd_data(fifo_rd_data),
    .fifo_empty(fifo_count == '0), .dir_wr(dir_wr), .dir_data(dir_data),
    .fifo_pop(fifo_pop), .load(load), .sample(sample), .underflow(underflow)
  );

  tos_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .width(cfg_width), .lane(cfg_lane), .sample(sample),
    .wdata(wdata), .bena(bena)
  );

  for (genvar b = 0; b < NBYTE; b++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)                  out_lines[b*8 +: 8] <= '0;
      else if (load && bena[b]) out_lines[b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fill_status <= '0;
    else     fill_status <= STAT_W'(fifo_count);
  end

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !upd_strobe |=> $stable(out_lines));
  p_byte0_keeps_rest_r2: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && cfg_width == 2'd0 && cfg_lane == 2'd0)
      |=> out_lines[DATA_W-1:8] == $past(out_lines[DATA_W-1:8]));
  p_half_low_keeps_high_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && cfg_width == 2'd1 && !cfg_lane[0])
      |=> out_lines[DATA_W-1:16] == $past(out_lines[DATA_W-1:16]));
  p_status_follows_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> fill_status == STAT_W'($past(fifo_count)));
endmodule

// File: tb/tb_tos_lane_placer.sv
`timescale 1ns/1ps
module tb_tos_lane_placer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_width = 2'd0;
  logic [1:0]  cfg_lane = 2'd0;
  logic        cfg_bypass = 1'b0;
  logic        fifo_clr = 1'b0;
  logic        upd_strobe = 1'b0;
  logic [31:0] fifo_rd_data = '0;
  logic [10:0] fifo_count = '0;
  logic        fifo_pop;
  logic        dir_wr = 1'b0;
  logic [31:0] dir_data = '0;
  logic [31:0] out_lines;
  logic        underflow;
  logic [15:0] fill_status;

  always #10 clk = ~clk;

  tos_lane_placer dut (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_lane(cfg_lane),
    .cfg_bypass(cfg_bypass), .fifo_clr(fifo_clr), .upd_strobe(upd_strobe),
    .fifo_rd_data(fifo_rd_data), .fifo_count(fifo_count), .fifo_pop(fifo_pop),
    .dir_wr(dir_wr), .dir_data(dir_data), .out_lines(out_lines),
    .underflow(underflow), .fill_status(fill_status)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] q[$];
  // reference model state
  logic [31:0] m_out = '0, m_dreg = '0;
  logic        m_uf = 1'b0, m_stale = 1'b0;
  logic [15:0] m_stat = '0;
  logic [1:0]  m_wq = 2'd0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: present FIFO head, check pop, advance model, check outputs
  task automatic cyc(input string tag);
    logic        e_pop, req;
    logic [31:0] smp, nout;
    int          w;
    fifo_rd_data = (q.size() > 0) ? q[0] : 32'h0;
    fifo_count   = 11'(q.size());
    #1;
    req   = upd_strobe && !cfg_bypass && !m_stale && !rst;
    e_pop = req && (q.size() > 0);
    chk(tag, "fifo_pop", {31'd0, fifo_pop}, {31'd0, e_pop});
    nout = m_out;
    smp  = cfg_bypass ? m_dreg : fifo_rd_data;
    if (!rst && upd_strobe && (cfg_bypass || e_pop)) begin
      w = (cfg_width == 2'd0) ? 8 : (cfg_width == 2'd1) ? 16 : 32;
      for (int i = 0; i < 32; i++) begin
        if (w == 8 && (i / 8) == cfg_lane) nout[i] = smp[i % 8];
        else if (w == 16 && (i / 16) == cfg_lane[0]) nout[i] = smp[i % 16];
        else if (w == 32) nout[i] = smp[i];
      end
    end
    @(posedge clk);
    if (e_pop) void'(q.pop_front());
    if (rst) begin
      m_out = '0; m_dreg = '0; m_uf = 1'b0; m_stale = 1'b0; m_stat = '0;
      m_wq = cfg_width;
    end else begin
      m_out = nout;
      if (req && !e_pop) m_uf = 1'b1;
      m_stat = 16'(fifo_count);
      if (dir_wr) m_dreg = dir_data;
      if (cfg_width != m_wq) m_stale = 1'b1;
      else if (fifo_clr) m_stale = 1'b0;
      m_wq = cfg_width;
    end
    @(negedge clk);
    chk(tag, "out_lines", out_lines, m_out);
    chk(tag, "underflow", {31'd0, underflow}, {31'd0, m_uf});
    chk(tag, "fill_status", {16'd0, fill_status}, {16'd0, m_stat});
    upd_strobe = 1'b0; dir_wr = 1'b0; fifo_clr = 1'b0;
  endtask

  task automatic upd(input string tag, input logic [1:0] w, input logic [1:0] l);
    cfg_width = w; cfg_lane = l; upd_strobe = 1'b1;
    cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with FIFO data present and a strobe held off
    q.push_back(32'hA1B2C3D4);
    repeat (3) cyc("R1");
    rst = 1'b0;
    cyc("R1");
    // R9: occupancy tracks pushes
    q.push_back(32'h11223344); q.push_back(32'h55667788);
    q.push_back(32'h99AABBCC); q.push_back(32'hDDEEFF00);
    cyc("R9");
    // R2: byte lanes 0..3, R5 one pop each
    upd("R2", 2'd0, 2'd0);
    upd("R2", 2'd0, 2'd1);
    cyc("R6");
    upd("R2", 2'd0, 2'd2);
    upd("R2", 2'd0, 2'd3);
    // R7: one word left, then empty strobe
    upd("R5", 2'd0, 2'd1);
    upd("R7", 2'd0, 2'd2);
    cyc("R7");
    upd("R7", 2'd0, 2'd0);
    // R10: width change holds FIFO path
    q.push_back(32'h0000CAFE); q.push_back(32'h0000BEEF);
    q.push_back(32'h12345678); q.push_back(32'h9ABCDEF0);
    cfg_width = 2'd1;
    cyc("R10");
    upd("R10", 2'd1, 2'd0);
    upd("R10", 2'd1, 2'd1);
    fifo_clr = 1'b1;
    cyc("R10");
    // R3: halfword lanes, codes 2 and 3 use bit 0
    upd("R3", 2'd1, 2'd0);
    upd("R3", 2'd1, 2'd3);
    upd("R3", 2'd1, 2'd2);
    upd("R3", 2'd1, 2'd1);
    // R4: word width with nonzero lane and spare code
    q.push_back(32'h0F1E2D3C); q.push_back(32'h4B5A6978);
    cfg_width = 2'd2; cyc("R4");
    fifo_clr = 1'b1; cyc("R4");
    upd("R4", 2'd2, 2'd3);
    cfg_width = 2'd3; cyc("R4");
    fifo_clr = 1'b1; cyc("R4");
    upd("R4", 2'd3, 2'd1);
    repeat (3) cyc("R6");
    // R8: bypass, load in same cycle as strobe uses old value
    q.push_back(32'h77777777);
    cfg_bypass = 1'b1; dir_data = 32'hFEEDF00D; dir_wr = 1'b1;
    cyc("R8");
    dir_data = 32'h01020304; dir_wr = 1'b1;
    upd("R8", 2'd2, 2'd0);
    upd("R8", 2'd2, 2'd0);
    cfg_width = 2'd0; // R10: bypass still works while FIFO path on hold
    upd("R8", 2'd0, 2'd2);
    upd("R10", 2'd0, 2'd3);
    cfg_bypass = 1'b0;
    upd("R10", 2'd0, 2'd0);
    fifo_clr = 1'b1; cyc("R10");
    upd("R5", 2'd0, 2'd1);
    cyc("R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule